// File: doc/BRIEF.md
# Per-Chain Calibration Retention Table

This block keeps a small set of radio calibration words for each receive chain and can replay them into the analog front end when asked. Every chain owns a bank of six 28-bit entries. Entries 0 to 2 carry DC-offset values, entry 3 a filter setting, entry 4 the receive gain and entry 5 the peak-detector offset.

Software does not address the entries directly. Each chain has a command register and a data register. The command register carries an entry index, a direction bit and an access bit. Software first writes the index and direction with access at 0. It then sets access to 1 and polls until the block returns access to 0. A write stores the data register into the entry. A read leaves the entry value in the data register.

A control register holds an enable bit, an entry-selection mask and a force bit. Setting force while the block is enabled makes the block present every selected entry of every chain on a shared valid/index/data output bus. It presents one selected entry per cycle, in ascending index order, and all chains move together. The force bit clears when the replay ends.

Top module: `cal_retain_table`

## Requirements
- R1: After reset every table entry, every command and data register and the control register read 0, and `rfe_vld` is 0.
- R2: Writing a chain's command register (address 0x10 + 8·chain) with index in bits [2:0], bit 16 = 1 (write) and bit 17 = 1 (access) stores that chain's data register into the entry. Bit 17 reads 1 for exactly 4 bus reads issued back to back from the cycle after the command, and 0 afterwards.
- R3: A command with bit 16 = 0 and bit 17 = 1 loads the chain's data register (address 0x14 + 8·chain) with the entry value by the time bit 17 returns to 0.
- R4: A command write arriving while that chain's access bit is 1 is dropped entirely: its index, direction and access fields have no effect.
- R5: A write to a chain's data register while that chain's access bit is 1 is dropped.
- R6: An access to index 6 or 7 changes no entry. A read at such an index places 0 in the data register.
- R7: Writing the control register (address 0x00) with bit 0 = 1 and bit 1 = 1 starts a replay of the entries whose bit is set in mask bits [13:8]. Bit i of the mask selects entry i. One selected index is presented per cycle in ascending order, with `rfe_vld` = 1, the index on `rfe_idx` and chain c's entry on `rfe_data[28c +: 28]`. Control bit 1 reads 1 while the replay runs and 0 after it.
- R8: With bit 0 = 0, bit 1 has no effect and reads back 0. Writing bit 0 = 0 during a replay abandons it with no further outputs.
- R9: Command register writes arriving while a replay runs are dropped.
- R10: Reads have one cycle of latency. The control register reads back {mask[13:8], force[1], enable[0]}. Command registers read back {access[17], direction[16], index[2:0]}. Unmapped addresses read 0.
- R11: An access on one chain leaves every other chain's entries and registers untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Register write data |
| we | input | 1 | Register write strobe |
| re | input | 1 | Register read strobe |
| rdata | output | 32 | Read data, valid the cycle after `re` |
| rfe_vld | output | 1 | Replay word valid |
| rfe_idx | output | 3 | Entry index being replayed |
| rfe_data | output | 56 | Replayed entry of each chain, chain c at bits [28c +: 28] |

## Verification
The hardest situations to reach are the ones where two activities overlap in a narrow window. One is a second command or a data-register write landing during the four-cycle access window. Another is a command landing while a replay is draining, and a third is an enable being dropped one cycle after a force. The stimulus reaches them with back-to-back register writes on consecutive cycles, so each collision falls on a known cycle. Two full sweeps then confirm the outcomes. A behavioural model built on queues predicts every read and every replay output on every clock. Replay sequences with sparse masks confirm that unselected indices cost no cycles.

// File: rtl/crt_pkg.sv
package crt_pkg;
  localparam int BUS_W      = 32;
  localparam int AW         = 8;
  localparam int CTRL_ADDR  = 0;
  localparam int CMD_BASE   = 16;
  localparam int CHAIN_STEP = 8;
  localparam int DATA_OFS   = 4;
  localparam int B_EN       = 0;
  localparam int B_FORCE    = 1;
  localparam int B_MASK     = 8;
  localparam int B_WR       = 16;
  localparam int B_ACC      = 17;

  // lowest set bit of an 8-bit selection vector, 8 when empty
  function automatic logic [3:0] lowest_set(input logic [7:0] m);
    lowest_set = 4'd8;
    for (int i = 7; i >= 0; i--) begin
      if (m[i]) lowest_set = 4'(i);
    end
  endfunction

  function automatic logic [AW-1:0] cmd_addr(input int c);
    return AW'(CMD_BASE + c * CHAIN_STEP);
  endfunction

  function automatic logic [AW-1:0] data_addr(input int c);
    return AW'(CMD_BASE + c * CHAIN_STEP + DATA_OFS);
  endfunction
endpackage

// File: rtl/crt_bank.sv
module crt_bank
  import crt_pkg::*;
#(
  parameter int NE  = 6,
  parameter int DW  = 28,
  parameter int IW  = 3,
  parameter int LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [IW-1:0] cmd_idx_in,
  input  logic          cmd_wr_in,
  input  logic          cmd_acc_in,
  input  logic          dat_we,
  input  logic [DW-1:0] dat_wdata,
  input  logic [IW-1:0] rs_idx,
  output logic [IW-1:0] cmd_idx,
  output logic          cmd_wr,
  output logic          cmd_busy,
  output logic [DW-1:0] dat_q,
  output logic [DW-1:0] rs_word,
  output logic          acc_done
);
  localparam int CW = $clog2(LAT + 1);

  logic [DW-1:0] ent [NE];
  logic [CW-1:0] cnt;
  logic [DW-1:0] cur_word;
  logic          cmd_take;

  assign cmd_take = cmd_we && !cmd_busy;
  assign acc_done = cmd_busy && (cnt == CW'(1));

  // out-of-range indices match no entry and so yield 0
  always_comb begin
    rs_word  = '0;
    cur_word = '0;
    for (int e = 0; e < NE; e++) begin
      if (rs_idx == IW'(e))  rs_word  = ent[e];
      if (cmd_idx == IW'(e)) cur_word = ent[e];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_idx  <= '0;
      cmd_wr   <= 1'b0;
      cmd_busy <= 1'b0;
      cnt      <= '0;
      dat_q    <= '0;
      for (int e = 0; e < NE; e++) ent[e] <= '0;
    end else begin
      if (cmd_take) begin
        cmd_idx <= cmd_idx_in;
        cmd_wr  <= cmd_wr_in;
        if (cmd_acc_in) begin
          cmd_busy <= 1'b1;
          cnt      <= CW'(LAT);
        end
      end else if (cmd_busy) begin
        cnt <= cnt - CW'(1);
        if (acc_done) cmd_busy <= 1'b0;
      end

      if (acc_done && !cmd_wr) begin
        dat_q <= cur_word;
      end else if (dat_we && !cmd_busy) begin
        dat_q <= dat_wdata;
      end

      for (int e = 0; e < NE; e++) begin
        if (acc_done && cmd_wr && cmd_idx == IW'(e)) ent[e] <= dat_q;
      end
    end
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy && !acc_done |=> cmd_busy); // R2
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_busy |-> (cnt != '0) && (cnt <= CW'(LAT))); // R2
  AST_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_busy |=> $stable(cmd_idx) && $stable(cmd_wr)); // R4
  AST_DAT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we && cmd_busy && cmd_wr |=> $stable(dat_q)); // R5
endmodule

// File: rtl/crt_restore.sv
module crt_restore
  import crt_pkg::*;
#(
  parameter int NC = 2,
  parameter int NE = 6,
  parameter int DW = 28,
  parameter int IW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_nxt,
  input  logic             start,
  input  logic [NE-1:0]    mask,
  input  logic [NC*DW-1:0] words,
  output logic             busy,
  output logic [IW-1:0]    rs_idx,
  output logic             out_vld,
  output logic [IW-1:0]    out_idx,
  output logic [NC*DW-1:0] out_data
);
  logic [NE-1:0] rem;
  logic [3:0]    pk;
  logic          step;

  assign pk     = lowest_set(8'(rem));
  assign rs_idx = IW'(pk);
  assign step   = busy && (|rem);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rem      <= '0;
      out_vld  <= 1'b0;
      out_idx  <= '0;
      out_data <= '0;
    end else if (!en_nxt) begin
      busy    <= 1'b0;
      rem     <= '0;
      out_vld <= 1'b0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      rem     <= mask;
      out_vld <= 1'b0;
    end else begin
      out_vld <= step;
      if (step) begin
        out_idx  <= rs_idx;
        out_data <= words;
        rem      <= rem & ~(NE'(1) << pk);
      end else if (busy) begin
        busy <= 1'b0;
      end
    end
  end

  AST_VLD_IN_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> busy); // R7
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && $past(out_vld) |-> out_idx > $past(out_idx)); // R7
  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_nxt |=> !busy && !out_vld); // R8
endmodule

// File: rtl/crt_regif.sv
module crt_regif
  import crt_pkg::*;
#(
  parameter int NC = 2,
  parameter int NE = 6,
  parameter int DW = 28,
  parameter int IW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [BUS_W-1:0] wdata,
  input  logic             we,
  input  logic             re,
  input  logic             rs_busy,
  input  logic [NC*IW-1:0] cmd_idx_all,
  input  logic [NC-1:0]    cmd_wr_all,
  input  logic [NC-1:0]    cmd_busy_all,
  input  logic [NC*DW-1:0] dat_all,
  output logic [BUS_W-1:0] rdata,
  output logic             en_nxt,
  output logic             start,
  output logic [NC-1:0]    cmd_we,
  output logic [NC-1:0]    dat_we
);
  logic             en_q;
  logic [NE-1:0]    mask_q;
  logic             ctrl_hit;
  logic [BUS_W-1:0] rd_mux;

  assign ctrl_hit = (addr == AW'(CTRL_ADDR));
  assign en_nxt   = (we && ctrl_hit) ? wdata[B_EN] : en_q;
  assign start    = we && ctrl_hit && wdata[B_FORCE] && wdata[B_EN];

  for (genvar c = 0; c < NC; c++) begin : g_dec
    assign cmd_we[c] = we && (addr == cmd_addr(c)) && !rs_busy;
    assign dat_we[c] = we && (addr == data_addr(c));
  end

  always_comb begin
    rd_mux = '0;
    if (ctrl_hit) begin
      rd_mux[B_EN]        = en_q;
      rd_mux[B_FORCE]     = rs_busy;
      rd_mux[B_MASK+:NE]  = mask_q;
    end
    for (int c = 0; c < NC; c++) begin
      if (addr == cmd_addr(c)) begin
        rd_mux[IW-1:0] = cmd_idx_all[c*IW+:IW];
        rd_mux[B_WR]   = cmd_wr_all[c];
        rd_mux[B_ACC]  = cmd_busy_all[c];
      end
      if (addr == data_addr(c)) rd_mux[DW-1:0] = dat_all[c*DW+:DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= '0;
      rdata  <= '0;
    end else begin
      en_q <= en_nxt;
      if (we && ctrl_hit) mask_q <= wdata[B_MASK+:NE];
      if (re) rdata <= rd_mux;
    end
  end

  AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !re |=> $stable(rdata)); // R10
  AST_FORCE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    rs_busy |-> en_q); // R8
endmodule

// File: rtl/cal_retain_table.sv
module cal_retain_table
  import crt_pkg::*;
#(
  parameter int N_CHAIN = 2,
  parameter int N_ENTRY = 6,
  parameter int DATA_W  = 28,
  parameter int ACC_LAT = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [7:0]                      addr,
  input  logic [31:0]                     wdata,
  input  logic                            we,
  input  logic                            re,
  output logic [31:0]                     rdata,
  output logic                            rfe_vld,
  output logic [$clog2(N_ENTRY+1)-1:0]    rfe_idx,
  output logic [N_CHAIN*DATA_W-1:0]       rfe_data
);
  localparam int IW = $clog2(N_ENTRY + 1);

  logic [N_CHAIN*IW-1:0]     cmd_idx_all;
  logic [N_CHAIN-1:0]        cmd_wr_all;
  logic [N_CHAIN-1:0]        cmd_busy_all;
  logic [N_CHAIN*DATA_W-1:0] dat_all;
  logic [N_CHAIN*DATA_W-1:0] words;
  logic [N_CHAIN-1:0]        cmd_we;
  logic [N_CHAIN-1:0]        dat_we;
  logic [N_CHAIN-1:0]        acc_done;
  logic                      en_nxt;
  logic                      start;
  logic                      rs_busy;
  logic [IW-1:0]             rs_idx;
  logic                      unused_bits;

  assign unused_bits = ^wdata;

  crt_regif #(.NC(N_CHAIN), .NE(N_ENTRY), .DW(DATA_W), .IW(IW)) u_regif (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rs_busy(rs_busy), .cmd_idx_all(cmd_idx_all), .cmd_wr_all(cmd_wr_all),
    .cmd_busy_all(cmd_busy_all), .dat_all(dat_all), .rdata(rdata),
    .en_nxt(en_nxt), .start(start), .cmd_we(cmd_we), .dat_we(dat_we)
  );

  for (genvar c = 0; c < N_CHAIN; c++) begin : g_bank
    crt_bank #(.NE(N_ENTRY), .DW(DATA_W), .IW(IW), .LAT(ACC_LAT)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .cmd_we(cmd_we[c]), .cmd_idx_in(wdata[IW-1:0]),
      .cmd_wr_in(wdata[B_WR]), .cmd_acc_in(wdata[B_ACC]),
      .dat_we(dat_we[c]), .dat_wdata(wdata[DATA_W-1:0]),
      .rs_idx(rs_idx),
      .cmd_idx(cmd_idx_all[c*IW+:IW]), .cmd_wr(cmd_wr_all[c]),
      .cmd_busy(cmd_busy_all[c]), .dat_q(dat_all[c*DATA_W+:DATA_W]),
      .rs_word(words[c*DATA_W+:DATA_W]), .acc_done(acc_done[c])
    );

    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done[c] |=> !cmd_busy_all[c]); // R2
  end

  crt_restore #(.NC(N_CHAIN), .NE(N_ENTRY), .DW(DATA_W), .IW(IW)) u_restore (
    .clk(clk), .rst_n(rst_n), .en_nxt(en_nxt), .start(start),
    .mask(wdata[B_MASK+:N_ENTRY]), .words(words), .busy(rs_busy),
    .rs_idx(rs_idx), .out_vld(rfe_vld), .out_idx(rfe_idx), .out_data(rfe_data)
  );

  AST_NO_ACCESS_START_IN_REPLAY: assert property (@(posedge clk) disable iff (!rst_n)
    rs_busy && $past(rs_busy) |-> !$rose(cmd_busy_all[0])); // R9
endmodule

// File: tb/tb_cal_retain_table.sv
module tb_cal_retain_table;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic        rfe_vld;
  logic [2:0]  rfe_idx;
  logic [55:0] rfe_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cal_retain_table dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .rfe_vld(rfe_vld), .rfe_idx(rfe_idx), .rfe_data(rfe_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          m_en, m_mask, m_rbusy, m_vld, m_idx;
  int          m_q[$];
  logic [27:0] m_out[2];
  logic [27:0] m_tbl[2][6];
  logic [27:0] m_dat[2];
  int          m_cidx[2], m_cwr[2], m_acc[2], m_cnt[2];
  logic [31:0] m_rdata;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] r = 0;
    if (a == 8'h00) r = (32'(m_mask) << 8) | (32'(m_rbusy) << 1) | 32'(m_en);
    for (int c = 0; c < 2; c++) begin
      if (a == 8'(16 + 8*c)) r = 32'(m_cidx[c]) | (32'(m_cwr[c]) << 16) | (32'(m_acc[c]) << 17);
      if (a == 8'(20 + 8*c)) r = 32'(m_dat[c]);
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_mask = 0; m_rbusy = 0; m_vld = 0; m_idx = 0; m_q.delete();
      m_rdata = 0;
      for (int c = 0; c < 2; c++) begin
        m_out[c] = 0; m_dat[c] = 0; m_cidx[c] = 0; m_cwr[c] = 0; m_acc[c] = 0; m_cnt[c] = 0;
        for (int e = 0; e < 6; e++) m_tbl[c][e] = 0;
      end
    end else begin
      bit ctl_w;
      int en_n, rb_old;
      ctl_w = we && addr == 8'h00;
      rb_old = m_rbusy;
      if (re) m_rdata = m_read(addr);
      en_n = ctl_w ? int'(wdata[0]) : m_en;
      if (en_n == 0) begin
        m_rbusy = 0; m_q.delete(); m_vld = 0;
      end else if (ctl_w && wdata[1] && m_rbusy == 0) begin
        m_rbusy = 1; m_q.delete(); m_vld = 0;
        for (int i = 0; i < 6; i++) if (wdata[8+i]) m_q.push_back(i);
      end else if (m_rbusy != 0 && m_q.size() > 0) begin
        m_vld = 1; m_idx = m_q.pop_front();
        for (int c = 0; c < 2; c++) m_out[c] = m_tbl[c][m_idx];
      end else begin
        m_rbusy = 0; m_vld = 0;
      end
      for (int c = 0; c < 2; c++) begin
        int acc_old;
        acc_old = m_acc[c];
        if (acc_old != 0) begin
          if (m_cnt[c] == 1) begin
            m_acc[c] = 0;
            if (m_cwr[c] != 0) begin
              if (m_cidx[c] < 6) m_tbl[c][m_cidx[c]] = m_dat[c];
            end else begin
              m_dat[c] = (m_cidx[c] < 6) ? m_tbl[c][m_cidx[c]] : 28'd0;
            end
          end
          m_cnt[c]--;
        end else if (we && addr == 8'(16 + 8*c) && rb_old == 0) begin
          m_cidx[c] = int'(wdata[2:0]);
          m_cwr[c]  = int'(wdata[16]);
          if (wdata[17]) begin m_acc[c] = 1; m_cnt[c] = 4; end
        end
        if (acc_old == 0 && we && addr == 8'(20 + 8*c)) m_dat[c] = wdata[27:0];
      end
      if (ctl_w) begin m_en = int'(wdata[0]); m_mask = int'(wdata[13:8]); end
    end
  end

  // per-cycle comparison and replay capture
  int          obs_idx[$];
  logic [27:0] obs_d0[$];
  logic [27:0] obs_d1[$];

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R10 model rdata", 64'(rdata), 64'(m_rdata));
      chk("R7 model rfe_vld", 64'(rfe_vld), 64'(m_vld));
      if (m_vld != 0) begin
        chk("R7 model rfe_idx", 64'(rfe_idx), 64'(m_idx));
        chk("R7 model rfe_data", 64'(rfe_data), {8'h0, m_out[1], m_out[0]});
      end
      if (rfe_vld) begin
        obs_idx.push_back(int'(rfe_idx));
        obs_d0.push_back(rfe_data[27:0]);
        obs_d1.push_back(rfe_data[55:28]);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=finish", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- bus tasks (entered at a falling edge) ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] q);
    re = 1; addr = a;
    @(negedge clk);
    re = 0;
    q = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tbl_write(input int c, input int i, input logic [27:0] d);
    wr(8'(20 + 8*c), 32'(d));
    wr(8'(16 + 8*c), 32'(i) | 32'h10000);
    wr(8'(16 + 8*c), 32'(i) | 32'h30000);
    idle(5);
  endtask

  task automatic tbl_read(input int c, input int i, output logic [27:0] d);
    logic [31:0] q;
    wr(8'(16 + 8*c), 32'(i));
    wr(8'(16 + 8*c), 32'(i) | 32'h20000);
    idle(5);
    rd(8'(20 + 8*c), q);
    d = q[27:0];
  endtask

  function automatic logic [27:0] ev(input int c, input int i);
    return 28'(32'h0A5A000 ^ (c << 20) ^ (i * 32'h1357));
  endfunction

  logic [27:0] exp_t[2][6];

  task automatic replay_check(input string tag, input int sel, input int n_wait);
    int k;
    obs_idx.delete(); obs_d0.delete(); obs_d1.delete();
    wr(8'h00, (32'(sel) << 8) | 32'h3);
    idle(n_wait);
    k = 0;
    for (int i = 0; i < 6; i++) begin
      if (sel[i]) begin
        if (k < obs_idx.size()) begin
          chk({tag, " index"}, 64'(obs_idx[k]), 64'(i));
          chk({tag, " chain0 word"}, 64'(obs_d0[k]), 64'(exp_t[0][i]));
          chk({tag, " chain1 word"}, 64'(obs_d1[k]), 64'(exp_t[1][i]));
        end
        k++;
      end
    end
    chk({tag, " count"}, 64'(obs_idx.size()), 64'(k));
  endtask

  initial begin
    logic [31:0] q;
    logic [27:0] d;
    int ones;
    for (int c = 0; c < 2; c++) for (int i = 0; i < 6; i++) exp_t[c][i] = ev(c, i);

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1: reset state
    rd(8'h00, q);  chk("R1 ctrl after reset", 64'(q), 0);
    rd(8'h14, q);  chk("R1 data0 after reset", 64'(q), 0);
    rd(8'h18, q);  chk("R1 cmd1 after reset", 64'(q), 0);
    chk("R1 rfe_vld after reset", 64'(rfe_vld), 0);
    tbl_read(1, 3, d); chk("R1 entry1.3 after reset", 64'(d), 0);

    // R2: write with access latency
    wr(8'h14, 32'(exp_t[0][0]));
    wr(8'h10, 32'h10000);
    wr(8'h10, 32'h30000);
    ones = 0;
    for (int k = 0; k < 6; k++) begin
      rd(8'h10, q);
      if (q[17]) ones++;
    end
    chk("R2 access busy reads", 64'(ones), 4);
    chk("R2 command after completion", 64'(q), 64'h10000);
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 6; i++)
        if (!(c == 0 && i == 0)) tbl_write(c, i, exp_t[c][i]);

    // R3: read back every entry
    for (int c = 0; c < 2; c++)
      for (int i = 0; i < 6; i++) begin
        tbl_read(c, i, d);
        chk("R3 entry readback", 64'(d), 64'(exp_t[c][i]));
      end

    // R4: second command during access is dropped
    wr(8'h10, 32'h1);
    wr(8'h10, 32'h20001);
    wr(8'h10, 32'h30004);
    idle(5);
    rd(8'h10, q); chk("R4 command fields kept", 64'(q), 64'h1);
    rd(8'h14, q); chk("R4 read result kept", 64'(q), 64'(exp_t[0][1]));
    tbl_read(0, 4, d); chk("R4 entry4 untouched", 64'(d), 64'(exp_t[0][4]));

    // R5: data write during a write access is dropped
    wr(8'h14, 32'h0C0FFEE);
    wr(8'h10, 32'h10002);
    wr(8'h10, 32'h30002);
    wr(8'h14, 32'h0BADBAD);
    idle(5);
    exp_t[0][2] = 28'h0C0FFEE;
    rd(8'h14, q); chk("R5 data register kept", 64'(q), 64'h0C0FFEE);
    tbl_read(0, 2, d); chk("R5 stored word", 64'(d), 64'h0C0FFEE);

    // R11: other chain untouched
    exp_t[1][2] = 28'h0123456;
    tbl_write(1, 2, 28'h0123456);
    tbl_read(0, 2, d); chk("R11 chain0 entry2 intact", 64'(d), 64'h0C0FFEE);
    tbl_read(1, 2, d); chk("R11 chain1 entry2 new", 64'(d), 64'h0123456);

    // R6: out-of-range index
    tbl_write(0, 6, 28'h0FFFFFF);
    for (int i = 0; i < 6; i++) begin
      tbl_read(0, i, d);
      chk("R6 no update at index 6", 64'(d), 64'(exp_t[0][i]));
    end
    wr(8'h14, 32'h0777777);
    tbl_read(0, 7, d); chk("R6 read index 7 gives 0", 64'(d), 0);

    // R7: replay selections
    replay_check("R7 mask 0x30", 32'h30, 6);
    rd(8'h00, q); chk("R7 ctrl after replay", 64'(q), 64'h3001);
    wr(8'h00, 32'h2D03);
    rd(8'h00, q); chk("R7 force bit during replay", 64'(q[1]), 1);
    idle(8);
    replay_check("R7 mask 0x2D", 32'h2D, 8);
    replay_check("R7 mask 0x10", 32'h10, 5);

    // R9: command during replay dropped
    wr(8'h00, 32'h3F03);
    wr(8'h10, 32'h30003);
    idle(10);
    rd(8'h10, q); chk("R9 command dropped in replay", 64'(q), 64'h7);

    // R8: disabled force, and abort
    obs_idx.delete();
    wr(8'h00, 32'h3002);
    rd(8'h00, q); chk("R8 force reads 0 when off", 64'(q), 64'h3000);
    idle(4);
    chk("R8 no replay when off", 64'(obs_idx.size()), 0);
    wr(8'h00, 32'h3F03);
    wr(8'h00, 32'h3F00);
    idle(6);
    chk("R8 abort yields no output", 64'(obs_idx.size()), 0);
    rd(8'h00, q); chk("R8 ctrl after abort", 64'(q), 64'h3F00);

    // R10: unmapped addresses
    rd(8'h04, q); chk("R10 unmapped 0x04", 64'(q), 0);
    rd(8'h40, q); chk("R10 unmapped 0x40", 64'(q), 0);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule